// File: doc/BRIEF.md
# Serial Flash Geometry Probe

This block identifies which page-buffered serial flash sits on a chip-select line and reports its array geometry: number of pages, bytes per page, the bit shift that places the page number in a flash address, and whether the part runs with power-of-two pages. A probe starts with a request pulse. The block first reads the three-byte manufacturer/device identifier. It then reads the status byte, either to pick between the two page-size variants of a recognised part or, when the identifier does not come from the expected manufacturer, to decode the legacy density code held in status bits 5:2.

All bus traffic goes through a byte-level handshake to an external SPI master. The block presents one byte together with a frame-end marker, and it holds both until the master acknowledges the byte and returns the byte it received. When the probe ends, a one-cycle done strobe comes with either a success flag or an error flag. The flags and the geometry stay unchanged until the next probe request.

Top module: `flash_geom_probe`

## Requirements
- R1: After reset, the done, ok and error flags, the transfer request and all geometry outputs are 0.
- R2: A start pulse while idle issues the byte 0x9F with frame-end 0, then three 0x00 bytes with frame-end set only on the third. The three received bytes form the identifier, with the manufacturer byte first and most significant.
- R3: If the manufacturer byte is not 0x1F, the block issues 0xD7 (frame-end 0) and then 0x00 (frame-end 1), and decodes the second received byte as a legacy status byte.
- R4: Legacy decode uses status AND 0x3C. 0x0C gives 512 pages of 264 bytes with shift 9, 0x14 gives 1024x264/9, 0x1C gives 2048x264/9, 0x24 gives 4096x264/9, 0x2C gives 4096x528/10, 0x34 gives 8192x528/10, and 0x38 or 0x3C gives 8192x1056/11. All of these report pow2 = 0.
- R5: A legacy status of 0x00 or 0xFF (no device), or any other masked code, ends the probe with the error flag set and all geometry outputs at 0.
- R6: The identifiers 0x1F2200, 0x1F2300, 0x1F2400, 0x1F2500, 0x1F2600, 0x1F2701 and 0x1F2800 are followed by a status read as in R3. If status bit 0 is 0, the result is the same density class as R4 (in that order) with pow2 = 0. If bit 0 is 1, page size and shift are both reduced to the power of two below them (256/8, 512/9, 1024/10) and pow2 = 1.
- R7: Identifier 0x1F2700 ends the probe without a status read and reports 8192 pages of 528 bytes, shift 10, pow2 = 0.
- R8: Any other identifier whose manufacturer byte is 0x1F ends the probe with the error flag and no status read.
- R9: Every result is marked by a one-cycle done pulse with exactly one of ok and error set. A start pulse clears ok and error. Flags and geometry then hold until the next result. A start pulse during a probe is ignored.
- R10: While the transfer request is high and not acknowledged, the request, the byte and the frame-end marker stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| probe_start | input | 1 | Probe request pulse |
| spi_req | output | 1 | Byte transfer request to the SPI master |
| spi_tx | output | 8 | Byte to shift out |
| spi_last | output | 1 | Release chip select after this byte |
| spi_ack | input | 1 | One-cycle byte completion from the master |
| spi_rx | input | 8 | Byte shifted in, valid with spi_ack |
| probe_done | output | 1 | One-cycle result strobe |
| probe_ok | output | 1 | Geometry valid |
| probe_err | output | 1 | Device absent or unsupported |
| geo_pages | output | 16 | Number of pages |
| geo_size | output | 11 | Bytes per page |
| geo_shift | output | 4 | Page-number shift inside a flash address |
| geo_pow2 | output | 1 | Power-of-two page mode in use |

## Verification
The assertions check the following on every cycle: the request is held stable until it is acknowledged; ok and error are never set together and only rise with done; geometry changes only on done; and every successful result has a consistent size and shift, meaning an exact power of two equal to 1 << shift in binary mode, and a two-bit size between the neighbouring powers of two otherwise. Only the bench scenarios can show that the byte sequence on the handshake is right, that each identifier and status code maps to the right table entry, that a status read is skipped where R7 and R8 require, and that a start pulse during a probe is ignored.

// File: rtl/flash_probe_pkg.sv
// Shared constants, types and geometry helpers for the flash probe.
// Assumes the density classes 0..6 are common to identifier and legacy decode.
package flash_probe_pkg;
    localparam int PAGES_W  = 16;
    localparam int SIZE_W   = 11;
    localparam int SHIFT_W  = 4;
    localparam int CLS_W    = 3;
    localparam int ID_BYTES = 3;
    localparam int CNT_W    = $clog2(ID_BYTES);
    localparam int ID_W     = 8 * ID_BYTES;

    localparam logic [7:0] OPC_IDENT  = 8'h9F;
    localparam logic [7:0] OPC_STATUS = 8'hD7;
    localparam logic [7:0] FILL_BYTE  = 8'h00;
    localparam logic [7:0] MFR_CODE   = 8'h1F;
    localparam logic [7:0] DEV_FIRST  = 8'h22;
    localparam logic [7:0] DEV_LAST   = 8'h28;
    localparam logic [7:0] DEV_DUAL   = 8'h27;
    localparam logic [7:0] DENS_MASK  = 8'h3C;

    typedef struct packed {
        logic [PAGES_W-1:0] pages;
        logic [SIZE_W-1:0]  size;
        logic [SHIFT_W-1:0] shift;
        logic               pow2;
    } geom_t;

    typedef enum logic [2:0] {
        S_IDLE, S_ID_OP, S_ID_RD, S_ID_EVAL, S_SR_OP, S_SR_RD, S_SR_EVAL
    } probe_state_t;

    // Base (non-binary) geometry of a density class.
    function automatic geom_t class_geom(input logic [CLS_W-1:0] cls);
        geom_t g;
        g.pow2 = 1'b0;
        case (cls)
            3'd0:    g.pages = PAGES_W'(512);
            3'd1:    g.pages = PAGES_W'(1024);
            3'd2:    g.pages = PAGES_W'(2048);
            3'd3,
            3'd4:    g.pages = PAGES_W'(4096);
            default: g.pages = PAGES_W'(8192);
        endcase
        if (cls < 3'd4) begin
            g.size = SIZE_W'(264);  g.shift = SHIFT_W'(9);
        end else if (cls < 3'd6) begin
            g.size = SIZE_W'(528);  g.shift = SHIFT_W'(10);
        end else begin
            g.size = SIZE_W'(1056); g.shift = SHIFT_W'(11);
        end
        return g;
    endfunction

    // Binary page variant: page size drops to the power of two below.
    function automatic geom_t to_binary(input geom_t g);
        geom_t b;
        b.pages = g.pages;
        b.shift = g.shift - SHIFT_W'(1);
        b.size  = SIZE_W'(1) << b.shift;
        b.pow2  = 1'b1;
        return b;
    endfunction
endpackage

// File: rtl/id_class_decode.sv
// Maps a 24-bit identifier to a density class and binary-page capability.
// Assumes: pure combinational; hit is 0 for any foreign or unlisted identifier.
module id_class_decode
    import flash_probe_pkg::*;
(
    input  logic [ID_W-1:0]  id_word,
    output logic             id_hit,
    output logic             id_bin,
    output logic [CLS_W-1:0] id_cls
);
    logic [7:0] dev_hi;
    logic [7:0] dev_lo;
    logic [7:0] dev_off;

    assign dev_hi  = id_word[15:8];
    assign dev_lo  = id_word[7:0];
    assign dev_off = dev_hi - DEV_FIRST;

    // Table lookup: listed device bytes, with a dual-revision entry.
    always_comb begin
        id_hit = 1'b0;
        id_bin = 1'b0;
        id_cls = dev_off[CLS_W-1:0];
        if (id_word[23:16] == MFR_CODE && dev_hi >= DEV_FIRST && dev_hi <= DEV_LAST) begin
            if (dev_lo == 8'h00) begin
                id_hit = 1'b1;
                id_bin = (dev_hi != DEV_DUAL);
            end else if (dev_hi == DEV_DUAL && dev_lo == 8'h01) begin
                id_hit = 1'b1;
                id_bin = 1'b1;
            end
        end
    end
endmodule

// File: rtl/status_class_decode.sv
// Decodes the legacy density code carried in status bits 5:2.
// Assumes: 0x00 and 0xFF mean an empty socket; pure combinational.
module status_class_decode
    import flash_probe_pkg::*;
(
    input  logic [7:0]       sr_byte,
    output logic             sr_hit,
    output logic [CLS_W-1:0] sr_cls
);
    logic [7:0] code;
    assign code = sr_byte & DENS_MASK;

    // Density code to class; absent device or unknown code gives a miss.
    always_comb begin
        sr_hit = 1'b0;
        sr_cls = '0;
        if (sr_byte != 8'h00 && sr_byte != 8'hFF) begin
            sr_hit = 1'b1;
            case (code)
                8'h0C:        sr_cls = 3'd0;
                8'h14:        sr_cls = 3'd1;
                8'h1C:        sr_cls = 3'd2;
                8'h24:        sr_cls = 3'd3;
                8'h2C:        sr_cls = 3'd4;
                8'h34:        sr_cls = 3'd5;
                8'h38, 8'h3C: sr_cls = 3'd6;
                default:      sr_hit = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/flash_probe_seq.sv
// Probe sequencer: drives the byte handshake, captures identifier and status,
// and registers the result. Assumes the master answers each request with a
// one-cycle ack and samples the next request after that ack.
module flash_probe_seq
    import flash_probe_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             req,
    output logic [7:0]       tx,
    output logic             last,
    input  logic             ack,
    input  logic [7:0]       rx,
    output logic [ID_W-1:0]  id_word,
    output logic [7:0]       sr_byte,
    input  logic             id_hit,
    input  logic             id_bin,
    input  logic [CLS_W-1:0] id_cls,
    input  logic             sr_hit,
    input  logic [CLS_W-1:0] sr_cls,
    output logic             done,
    output logic             ok,
    output logic             err,
    output geom_t            geom
);
    probe_state_t     state;
    logic [CNT_W-1:0] rd_cnt;
    logic             legacy;

    // Handshake outputs follow the state alone.
    always_comb begin
        req  = (state == S_ID_OP) || (state == S_ID_RD) ||
               (state == S_SR_OP) || (state == S_SR_RD);
        tx   = (state == S_ID_OP) ? OPC_IDENT :
               (state == S_SR_OP) ? OPC_STATUS : FILL_BYTE;
        last = (state == S_SR_RD) ||
               (state == S_ID_RD && rd_cnt == CNT_W'(ID_BYTES - 1));
    end

    // Probe state machine and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            rd_cnt  <= '0;
            legacy  <= 1'b0;
            id_word <= '0;
            sr_byte <= '0;
            done    <= 1'b0;
            ok      <= 1'b0;
            err     <= 1'b0;
            geom    <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                S_IDLE: if (start) begin
                    ok     <= 1'b0;
                    err    <= 1'b0;
                    rd_cnt <= '0;
                    state  <= S_ID_OP;
                end
                S_ID_OP: if (ack) state <= S_ID_RD;
                S_ID_RD: if (ack) begin
                    id_word <= {id_word[ID_W-9:0], rx};
                    if (rd_cnt == CNT_W'(ID_BYTES - 1)) state <= S_ID_EVAL;
                    else rd_cnt <= rd_cnt + CNT_W'(1);
                end
                S_ID_EVAL: begin
                    if (id_word[ID_W-1:ID_W-8] != MFR_CODE) begin
                        legacy <= 1'b1;
                        state  <= S_SR_OP;
                    end else if (id_hit && id_bin) begin
                        legacy <= 1'b0;
                        state  <= S_SR_OP;
                    end else begin
                        done  <= 1'b1;
                        ok    <= id_hit;
                        err   <= !id_hit;
                        geom  <= id_hit ? class_geom(id_cls) : '0;
                        state <= S_IDLE;
                    end
                end
                S_SR_OP: if (ack) state <= S_SR_RD;
                S_SR_RD: if (ack) begin
                    sr_byte <= rx;
                    state   <= S_SR_EVAL;
                end
                S_SR_EVAL: begin
                    done  <= 1'b1;
                    state <= S_IDLE;
                    if (legacy) begin
                        ok   <= sr_hit;
                        err  <= !sr_hit;
                        geom <= sr_hit ? class_geom(sr_cls) : '0;
                    end else begin
                        ok   <= 1'b1;
                        err  <= 1'b0;
                        geom <= sr_byte[0] ? to_binary(class_geom(id_cls)) : class_geom(id_cls);
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/flash_geom_probe.sv
// Top of the flash geometry probe: sequencer plus the two class decoders.
// Assumes a byte-level SPI master on the spi_* handshake.
module flash_geom_probe
    import flash_probe_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               probe_start,
    output logic               spi_req,
    output logic [7:0]         spi_tx,
    output logic               spi_last,
    input  logic               spi_ack,
    input  logic [7:0]         spi_rx,
    output logic               probe_done,
    output logic               probe_ok,
    output logic               probe_err,
    output logic [PAGES_W-1:0] geo_pages,
    output logic [SIZE_W-1:0]  geo_size,
    output logic [SHIFT_W-1:0] geo_shift,
    output logic               geo_pow2
);
    logic [ID_W-1:0]  id_word;
    logic [7:0]       sr_byte;
    logic             id_hit, id_bin, sr_hit;
    logic [CLS_W-1:0] id_cls, sr_cls;
    geom_t            geom;

    id_class_decode u_id (
        .id_word (id_word), .id_hit (id_hit), .id_bin (id_bin), .id_cls (id_cls)
    );

    status_class_decode u_sr (
        .sr_byte (sr_byte), .sr_hit (sr_hit), .sr_cls (sr_cls)
    );

    flash_probe_seq u_seq (
        .clk     (clk),      .rst_n  (rst_n),    .start  (probe_start),
        .req     (spi_req),  .tx     (spi_tx),   .last   (spi_last),
        .ack     (spi_ack),  .rx     (spi_rx),
        .id_word (id_word),  .sr_byte(sr_byte),
        .id_hit  (id_hit),   .id_bin (id_bin),   .id_cls (id_cls),
        .sr_hit  (sr_hit),   .sr_cls (sr_cls),
        .done    (probe_done), .ok   (probe_ok), .err    (probe_err),
        .geom    (geom)
    );

    assign geo_pages = geom.pages;
    assign geo_size  = geom.size;
    assign geo_shift = geom.shift;
    assign geo_pow2  = geom.pow2;
endmodule

// File: rtl/flash_geom_probe_chk.sv
// Assertion checker for flash_geom_probe, attached by bind below.
// Assumes synchronous active-low reset; checks port behaviour only.
module flash_geom_probe_chk
    import flash_probe_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               spi_req,
    input logic [7:0]         spi_tx,
    input logic               spi_last,
    input logic               spi_ack,
    input logic               probe_done,
    input logic               probe_ok,
    input logic               probe_err,
    input logic [PAGES_W-1:0] geo_pages,
    input logic [SIZE_W-1:0]  geo_size,
    input logic [SHIFT_W-1:0] geo_shift,
    input logic               geo_pow2
);
    p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        spi_req && !spi_ack |=> spi_req && $stable(spi_tx) && $stable(spi_last));

    p_done_one_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        probe_done |-> (probe_ok ^ probe_err) && !spi_req);

    p_flags_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(probe_ok && probe_err));

    p_ok_rise_on_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(probe_ok) |-> probe_done);

    p_err_rise_on_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(probe_err) |-> probe_done);

    p_geo_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !probe_done |-> $stable(geo_pages) && $stable(geo_size) &&
                        $stable(geo_shift) && $stable(geo_pow2));

    p_err_geo_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        probe_err |-> geo_pages == '0 && geo_size == '0 && geo_shift == '0 && !geo_pow2);

    p_binary_size_r6: assert property (@(posedge clk) disable iff (!rst_n)
        probe_ok && geo_pow2 |-> $countones(geo_size) == 1 &&
                                 32'(geo_size) == (32'd1 << geo_shift));

    p_base_size_r4: assert property (@(posedge clk) disable iff (!rst_n)
        probe_ok && !geo_pow2 |-> $countones(geo_size) == 2 &&
            32'(geo_size) < (32'd1 << geo_shift) &&
            32'(geo_size) > (32'd1 << (geo_shift - 4'd1)));
endmodule

bind flash_geom_probe flash_geom_probe_chk u_chk (
    .clk        (clk),        .rst_n      (rst_n),
    .spi_req    (spi_req),    .spi_tx     (spi_tx),
    .spi_last   (spi_last),   .spi_ack    (spi_ack),
    .probe_done (probe_done), .probe_ok   (probe_ok),
    .probe_err  (probe_err),  .geo_pages  (geo_pages),
    .geo_size   (geo_size),   .geo_shift  (geo_shift),
    .geo_pow2   (geo_pow2)
);

// File: tb/tb_flash_geom_probe.sv
`timescale 1ns/1ps
// Bench: behavioural flash responder, per-clock model of the held result,
// and an expected byte queue for the handshake.
module tb_flash_geom_probe;
    localparam int LAT = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        probe_start = 1'b0;
    logic        spi_req, spi_last, spi_ack = 1'b0;
    logic [7:0]  spi_tx, spi_rx = 8'h00;
    logic        probe_done, probe_ok, probe_err, geo_pow2;
    logic [15:0] geo_pages;
    logic [10:0] geo_size;
    logic [3:0]  geo_shift;

    always #2.5 clk = ~clk;

    flash_geom_probe dut (.*);

    int n_checks = 0;
    int n_errs   = 0;

    logic [8:0] exp_q[$];
    logic [7:0] cfg_id[3];
    logic [7:0] cfg_st;

    int e_ok, e_err, e_pages, e_size, e_shift, e_p2;
    int h_ok = 0, h_err = 0, h_pages = 0, h_size = 0, h_shift = 0, h_p2 = 0;
    bit m_busy = 0;
    bit seen_done = 0;

    task automatic chk(input bit good, input string what, input string detail);
        n_checks++;
        if (!good) begin
            n_errs++;
            $display("FAIL %s: %s", what, detail);
        end
    endtask

    // Flash responder acting as the SPI master plus device.
    initial begin
        int wait_n = 0;
        int idx = 0;
        logic [7:0] opc = 8'h00;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                spi_ack = 1'b0; wait_n = 0; idx = 0;
            end else if (spi_ack) begin
                spi_ack = 1'b0;
            end else if (spi_req) begin
                wait_n++;
                if (wait_n == LAT) begin
                    logic [8:0] e;
                    wait_n = 0;
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R2 R3 R9 byte order",
                            $sformatf("act %0d/%02h exp none", spi_last, spi_tx));
                    end else begin
                        e = exp_q.pop_front();
                        chk({spi_last, spi_tx} == e, "R2 R3 R10 command byte",
                            $sformatf("act %0d/%02h exp %0d/%02h", spi_last, spi_tx, e[8], e[7:0]));
                    end
                    if (idx == 0) opc = spi_tx;
                    if (opc == 8'h9F && idx >= 1 && idx <= 3) spi_rx = cfg_id[idx-1];
                    else if (opc == 8'hD7 && idx == 1)        spi_rx = cfg_st;
                    else                                      spi_rx = 8'hFF;
                    spi_ack = 1'b1;
                    idx = spi_last ? 0 : idx + 1;
                end
            end
        end
    end

    // Per-clock comparison against the held-result model.
    initial begin
        forever begin
            @(posedge clk); #1;
            if (rst_n) begin
                if (probe_start && !m_busy) begin
                    h_ok = 0; h_err = 0; m_busy = 1;
                end
                if (probe_done) begin
                    chk(m_busy, "R9 done without probe", "act done=1 exp 0");
                    h_ok = e_ok; h_err = e_err; h_pages = e_pages;
                    h_size = e_size; h_shift = e_shift; h_p2 = e_p2;
                    m_busy = 0; seen_done = 1;
                end
                chk(probe_ok == h_ok && probe_err == h_err && geo_pages == h_pages &&
                    geo_size == h_size && geo_shift == h_shift && geo_pow2 == h_p2,
                    "R9 held result",
                    $sformatf("act ok=%0d err=%0d %0dx%0d sh%0d p2=%0d exp ok=%0d err=%0d %0dx%0d sh%0d p2=%0d",
                        probe_ok, probe_err, geo_pages, geo_size, geo_shift, geo_pow2,
                        h_ok, h_err, h_pages, h_size, h_shift, h_p2));
            end
        end
    end

    // Expected bytes and result from the requirement tables.
    task automatic predict(input logic [7:0] m, d, v, st);
        int pg = 0, sz = 0, sh = 0;
        bit sup = 0, known = 0, need;
        exp_q = {};
        exp_q.push_back({1'b0, 8'h9F});
        exp_q.push_back({1'b0, 8'h00});
        exp_q.push_back({1'b0, 8'h00});
        exp_q.push_back({1'b1, 8'h00});
        e_p2 = 0;
        if (m == 8'h1F) begin
            known = 1; sup = 1;
            case ({d, v})
                16'h2200: begin pg = 512;  sz = 264;  sh = 9;  end
                16'h2300: begin pg = 1024; sz = 264;  sh = 9;  end
                16'h2400: begin pg = 2048; sz = 264;  sh = 9;  end
                16'h2500: begin pg = 4096; sz = 264;  sh = 9;  end
                16'h2600: begin pg = 4096; sz = 528;  sh = 10; end
                16'h2700: begin pg = 8192; sz = 528;  sh = 10; sup = 0; end
                16'h2701: begin pg = 8192; sz = 528;  sh = 10; end
                16'h2800: begin pg = 8192; sz = 1056; sh = 11; end
                default:  begin known = 0; sup = 0; end
            endcase
            need = sup;
            if (sup && st[0]) begin sz = sz * 32 / 33; sh = sh - 1; e_p2 = 1; end
        end else begin
            need = 1;
            if (st != 8'h00 && st != 8'hFF) begin
                known = 1;
                case (st & 8'h3C)
                    8'h0C: begin pg = 512;  sz = 264;  sh = 9;  end
                    8'h14: begin pg = 1024; sz = 264;  sh = 9;  end
                    8'h1C: begin pg = 2048; sz = 264;  sh = 9;  end
                    8'h24: begin pg = 4096; sz = 264;  sh = 9;  end
                    8'h2C: begin pg = 4096; sz = 528;  sh = 10; end
                    8'h34: begin pg = 8192; sz = 528;  sh = 10; end
                    8'h38, 8'h3C: begin pg = 8192; sz = 1056; sh = 11; end
                    default: known = 0;
                endcase
            end
        end
        if (need) begin
            exp_q.push_back({1'b0, 8'hD7});
            exp_q.push_back({1'b1, 8'h00});
        end
        e_ok = known; e_err = !known;
        if (!known) begin pg = 0; sz = 0; sh = 0; e_p2 = 0; end
        e_pages = pg; e_size = sz; e_shift = sh;
    endtask

    task automatic run(input logic [7:0] m, d, v, st, input string tag, input bit poke);
        cfg_id[0] = m; cfg_id[1] = d; cfg_id[2] = v; cfg_st = st;
        predict(m, d, v, st);
        seen_done = 0;
        @(negedge clk); probe_start = 1'b1;
        @(negedge clk); probe_start = 1'b0;
        if (poke) begin
            repeat (5) @(negedge clk);
            probe_start = 1'b1;
            @(negedge clk); probe_start = 1'b0;
        end
        for (int i = 0; i < 300 && !seen_done; i++) @(negedge clk);
        chk(seen_done, {tag, " done strobe"}, $sformatf("act done=%0d exp 1", seen_done));
        chk(exp_q.size() == 0, {tag, " R7 R8 byte count"},
            $sformatf("act pending=%0d exp 0", exp_q.size()));
        chk(probe_ok == e_ok && probe_err == e_err && geo_pages == e_pages &&
            geo_size == e_size && geo_shift == e_shift && geo_pow2 == e_p2,
            {tag, " result"},
            $sformatf("act ok=%0d err=%0d %0dx%0d sh%0d p2=%0d exp ok=%0d err=%0d %0dx%0d sh%0d p2=%0d",
                probe_ok, probe_err, geo_pages, geo_size, geo_shift, geo_pow2,
                e_ok, e_err, e_pages, e_size, e_shift, e_p2));
        repeat (4) @(negedge clk);
    endtask

    // Watchdog: counts as a failed check, still prints the summary.
    initial begin
        #(200000 * 5);
        n_checks++; n_errs++;
        $display("FAIL watchdog: act running exp finished");
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!probe_done && !probe_ok && !probe_err && !spi_req && geo_pages == 0 &&
            geo_size == 0 && geo_shift == 0 && !geo_pow2, "R1 reset state",
            $sformatf("act done=%0d ok=%0d err=%0d req=%0d pages=%0d exp all 0",
                probe_done, probe_ok, probe_err, spi_req, geo_pages));
        run(8'h1F, 8'h24, 8'h00, 8'h80, "R6 base 2048", 0);
        run(8'h1F, 8'h24, 8'h00, 8'h81, "R6 binary 2048", 0);
        run(8'h1F, 8'h27, 8'h00, 8'h81, "R7 fixed 528", 0);
        run(8'h1F, 8'h27, 8'h01, 8'h81, "R6 dual binary", 0);
        run(8'h1F, 8'h28, 8'h00, 8'h80, "R6 base 1056", 0);
        run(8'h1F, 8'h26, 8'h00, 8'h81, "R6 binary 4096", 0);
        run(8'h1F, 8'h22, 8'h00, 8'h81, "R6 binary 512", 0);
        run(8'h1F, 8'h23, 8'h00, 8'h80, "R6 base 1024", 0);
        run(8'h1F, 8'h25, 8'h00, 8'h80, "R6 base 4096", 1);
        run(8'h1F, 8'h29, 8'h99, 8'h80, "R8 unknown id", 0);
        run(8'h1F, 8'h24, 8'h05, 8'h80, "R8 bad low byte", 0);
        run(8'hFF, 8'hFF, 8'hFF, 8'hFF, "R5 absent high", 0);
        run(8'h00, 8'h00, 8'h00, 8'h00, "R5 absent low", 0);
        run(8'h00, 8'h00, 8'h00, 8'h8C, "R3 R4 code 0C", 1);
        run(8'h00, 8'h00, 8'h00, 8'h94, "R4 code 14", 0);
        run(8'h00, 8'h00, 8'h00, 8'h9C, "R4 code 1C", 0);
        run(8'h00, 8'h00, 8'h00, 8'hA4, "R4 code 24", 0);
        run(8'h00, 8'h00, 8'h00, 8'hAC, "R4 code 2C", 0);
        run(8'h00, 8'h00, 8'h00, 8'hB4, "R4 code 34", 0);
        run(8'h00, 8'h00, 8'h00, 8'hB8, "R4 code 38", 0);
        run(8'hC2, 8'h20, 8'h00, 8'hBF, "R3 R4 code 3C", 0);
        run(8'h00, 8'h00, 8'h00, 8'h84, "R5 unsupported code", 0);
        repeat (10) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end
endmodule